// File: doc/BRIEF.md
# Processor Control Register Interface for a TDM Switch

This block is the byte-wide microprocessor port of a time-division channel switch. A host drives an asynchronous bus with an active-low select, an active-high data strobe, a read/write line, six address lines and eight data lines, and waits for an active-low acknowledge. The block synchronizes the strobe into the switch clock domain and decodes each access. It then either serves a local control register or forwards the access to one of three external memories: the data store, the connection-low array or the connection-high array. Memory accesses wait for a free memory access slot granted by the switch.

The memories are reached through a 32-location window. When address bit 5 is set, the low five address bits give the channel. A control register chooses which memory and which stream appear in the window. A split setting sends reads to the data store and writes to connection-low, so the host can monitor inputs and program connections without rewriting the control register. The control register also holds a global message-mode flag, which goes straight out to the switch datapath.

Top module: `tsw_cpu_port`

## Requirements
- R1: After reset, bus_ack_n is high, bus_rdata_oe is low, mem_req is low, ctl_msg_all is low and the control register reads back 0x00.
- R2: An access with bus_addr[5]=0 reaches the control register whatever bus_addr[4:0] holds, and it never raises mem_req. Control bit 5 has no storage and reads back 0.
- R3: ctl_msg_all follows control bit 6 from the cycle in which a control write is taken.
- R4: With control bit 7 clear, the memory field in control bits 4:3 picks the target on mem_sel (01 data store, 10 connection-low, 11 connection-high). mem_addr is {control bits 2:0, bus_addr[4:0]}.
- R5: With control bit 7 set, reads target the data store (mem_sel=01) and writes target connection-low (mem_sel=10), whatever the memory field holds.
- R6: mem_req stays high, with address, select and write flag stable, until a cycle with mem_slot high. Exactly one memory access (mem_req and mem_slot both high) happens per bus access.
- R7: Read data is mem_rdata as sampled one clock after the access cycle. For connection-high reads, bits 7:3 are returned as 0.
- R8: A write aimed at the data store, and any access while the memory field is 00 with bit 7 clear, makes no memory access and is still acknowledged. Such a read returns 0x00.
- R9: Once bus_ack_n falls, it stays low until the strobe is removed (bus_cs_n high or bus_ds low). It then rises, and a strobe that is held does not start a second access.
- R10: bus_rdata_oe is high only while bus_ack_n is low on a read, and it is never high during a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Host chip select, active low, asynchronous |
| bus_ds | input | 1 | Host data strobe, active high, asynchronous |
| bus_rd | input | 1 | 1 for read, 0 for write |
| bus_addr | input | 6 | Bit 5 selects the window; bits 4:0 give the channel |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data |
| bus_rdata_oe | output | 1 | Read data drive enable |
| bus_ack_n | output | 1 | Transfer acknowledge, active low |
| ctl_msg_all | output | 1 | Global message-mode flag (control bit 6) |
| mem_req | output | 1 | Memory access pending |
| mem_slot | input | 1 | Switch grants the memory port this cycle |
| mem_sel | output | 2 | Target memory: 01 data store, 10 connection-low, 11 connection-high |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 8 | {stream, channel} |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one clock after the access cycle |

## Verification
The assertions assume that the host keeps address, read/write and write data stable from the moment the strobe is asserted until acknowledge has fallen. They also assume that the external memory returns read data exactly one clock after a granted cycle. The bench changes the bus inputs only on the falling clock edge, and only while no transfer is in flight or after acknowledge has been released. Its memory model answers granted cycles with the one-clock latency. Slots come in a sparse repeating pattern, with one long blocked stretch, so that the hold-until-slot rule is exercised under both short and long waits.

// File: rtl/tsw_cpu_pkg.sv
package tsw_cpu_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'b00,
      SEL_DS   = 2'b01,
      SEL_CML  = 2'b10,
      SEL_CMH  = 2'b11
   } msel_e;

   // control register layout; positions are decoded by the datapath
   typedef struct packed {
      logic       split;
      logic       msg_all;
      logic       spare;
      msel_e      msel;
      logic [2:0] stream;
   } ctrl_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SLOT,
      ST_CAP,
      ST_ACK
   } port_st_e;

   // which memory a window access reaches
   function automatic msel_e route(ctrl_t c, logic rd);
      if (c.split) return rd ? SEL_DS : SEL_CML;
      return c.msel;
   endfunction

   // does the access need a memory cycle at all
   function automatic logic needs_mem(msel_e t, logic rd);
      return (t != SEL_NONE) && !((t == SEL_DS) && !rd);
   endfunction

endpackage

// File: rtl/tsw_sync.sv
module tsw_sync #(
   parameter int    WIDTH   = 1,
   parameter int    STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RST_VAL;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tsw_ctrl_reg.sv
module tsw_ctrl_reg
   import tsw_cpu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output ctrl_t             ctrl
);
   ctrl_t ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else if (we) ctrl_q <= ctrl_t'({wdata[7:6], 1'b0, wdata[4:0]});
   end

   assign ctrl = ctrl_q;
endmodule

// File: rtl/tsw_port_fsm.sv
module tsw_port_fsm
   import tsw_cpu_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic bus_rd,
   input  logic go_mem,
   input  logic mem_slot,
   output logic start,
   output logic req,
   output logic cap,
   output logic ack,
   output logic rd_q
);
   port_st_e st, st_nx;

   assign start = (st == ST_IDLE) && strobe;

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE: if (strobe) st_nx = go_mem ? ST_SLOT : ST_ACK;
         ST_SLOT: if (mem_slot) st_nx = rd_q ? ST_CAP : ST_ACK;
         ST_CAP:  st_nx = ST_ACK;
         ST_ACK:  if (!strobe) st_nx = ST_IDLE;
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         rd_q <= 1'b0;
      end else begin
         st <= st_nx;
         if (start) rd_q <= bus_rd;
      end
   end

   assign req = (st == ST_SLOT);
   assign cap = (st == ST_CAP);
   assign ack = (st == ST_ACK);
endmodule

// File: rtl/tsw_cpu_port.sv
module tsw_cpu_port
   import tsw_cpu_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 8,
   parameter int STREAM_W    = 3,
   parameter int CMH_W       = 3,
   parameter int SYNC_STAGES = 2,
   localparam int CH_W       = ADDR_W - 1,
   localparam int MA_W       = STREAM_W + CH_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_cs_n,
   input  logic              bus_ds,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rdata_oe,
   output logic              bus_ack_n,
   output logic              ctl_msg_all,
   output logic              mem_req,
   input  logic              mem_slot,
   output logic [1:0]        mem_sel,
   output logic              mem_we,
   output logic [MA_W-1:0]   mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   // elaboration checks
   if (DATA_W != 8) begin : g_bad_dw
      $error("control register layout needs DATA_W == 8");
   end
   if (STREAM_W < 1 || STREAM_W > 3) begin : g_bad_sw
      $error("STREAM_W must fit control bits 2:0");
   end
   if (CMH_W < 1 || CMH_W > DATA_W) begin : g_bad_cw
      $error("CMH_W out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CH_W < 1) begin : g_bad_aw
      $error("ADDR_W too small");
   end

   localparam logic [DATA_W-1:0] CMH_MASK = {{(DATA_W-CMH_W){1'b0}}, {CMH_W{1'b1}}};

   // strobe synchronization
   logic [1:0] sync_q;
   tsw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bus_cs_n, bus_ds}),
      .q     (sync_q)
   );
   logic strobe;
   assign strobe = !sync_q[1] && sync_q[0];

   // control register
   ctrl_t ctrl;
   logic  start, req, cap, ack, rd_q;
   logic  is_ctrl;
   assign is_ctrl = !bus_addr[ADDR_W-1];

   tsw_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (start && is_ctrl && !bus_rd),
      .wdata (bus_wdata),
      .ctrl  (ctrl)
   );

   // decode of a window access
   msel_e tgt;
   logic  go_mem;
   assign tgt    = route(ctrl, bus_rd);
   assign go_mem = !is_ctrl && needs_mem(tgt, bus_rd);

   tsw_port_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (strobe),
      .bus_rd   (bus_rd),
      .go_mem   (go_mem),
      .mem_slot (mem_slot),
      .start    (start),
      .req      (req),
      .cap      (cap),
      .ack      (ack),
      .rd_q     (rd_q)
   );

   // latched memory command
   msel_e             sel_q;
   logic              we_q;
   logic [MA_W-1:0]   addr_q;
   logic [DATA_W-1:0] wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= SEL_NONE;
         we_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (start && go_mem) begin
         sel_q   <= tgt;
         we_q    <= !bus_rd;
         addr_q  <= {ctrl.stream[STREAM_W-1:0], bus_addr[CH_W-1:0]};
         wdata_q <= bus_wdata;
      end
   end

   // read data path
   logic [DATA_W-1:0] cap_data;
   if (CMH_W < DATA_W) begin : g_mask
      assign cap_data = (sel_q == SEL_CMH) ? (mem_rdata & CMH_MASK) : mem_rdata;
   end else begin : g_nomask
      assign cap_data = mem_rdata;
   end

   logic [DATA_W-1:0] rdata_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else if (start) rdata_q <= is_ctrl ? DATA_W'(ctrl) : '0;
      else if (cap) rdata_q <= cap_data;
   end

   assign bus_rdata    = rdata_q;
   assign bus_rdata_oe = ack && rd_q;
   assign bus_ack_n    = !ack;
   assign ctl_msg_all  = ctrl.msg_all;
   assign mem_req      = req;
   assign mem_sel      = sel_q;
   assign mem_we       = we_q;
   assign mem_addr     = addr_q;
   assign mem_wdata    = wdata_q;
endmodule

// File: rtl/tsw_cpu_port_chk.sv
module tsw_cpu_port_chk #(
   parameter int MA_W   = 8,
   parameter int DATA_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_ack_n,
   input logic            bus_rdata_oe,
   input logic            mem_req,
   input logic            mem_slot,
   input logic [1:0]      mem_sel,
   input logic            mem_we,
   input logic [MA_W-1:0] mem_addr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (bus_ack_n && !bus_rdata_oe && !mem_req)
            else $error("port active during reset");
      end
   end

   assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_slot |=> mem_req && $stable(mem_addr) && $stable(mem_sel) && $stable(mem_we));

   assert_one_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_slot |=> !mem_req);

   assert_no_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_sel != 2'b00);

   assert_ds_readonly_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_sel == 2'b01 |-> !mem_we);

   assert_ack_after_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ack_n |-> !mem_req);

   assert_oe_in_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata_oe |-> !bus_ack_n);
endmodule

bind tsw_cpu_port tsw_cpu_port_chk #(.MA_W(MA_W), .DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_ack_n    (bus_ack_n),
   .bus_rdata_oe (bus_rdata_oe),
   .mem_req      (mem_req),
   .mem_slot     (mem_slot),
   .mem_sel      (mem_sel),
   .mem_we       (mem_we),
   .mem_addr     (mem_addr)
);

// File: tb/tsw_cpu_port_test.sv
module tsw_cpu_port_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_cs_n = 1'b1, bus_ds = 1'b0, bus_rd = 1'b0;
   logic [5:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       bus_rdata_oe, bus_ack_n, ctl_msg_all;
   logic       mem_req, mem_slot = 1'b0, mem_we;
   logic [1:0] mem_sel;
   logic [7:0] mem_addr, mem_wdata;
   logic [7:0] mem_rdata = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tsw_cpu_port uut (
      .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_ds(bus_ds), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rdata_oe(bus_rdata_oe), .bus_ack_n(bus_ack_n), .ctl_msg_all(ctl_msg_all),
      .mem_req(mem_req), .mem_slot(mem_slot), .mem_sel(mem_sel), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   int n_vec = 0, n_bad = 0;
   bit done = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // memory model with slot generator
   logic [7:0] ds_m [256];
   logic [7:0] cml_m [256];
   logic [7:0] cmh_m [256];
   int  acc_cnt = 0;
   bit  slot_block = 0;
   int  slot_cnt = 0;
   bit  hit_n = 0;
   logic [1:0] sel_n;
   logic       we_n;
   logic [7:0] addr_n, wd_n;

   always @(negedge clk) begin
      slot_cnt++;
      mem_slot = !slot_block && (slot_cnt % 3 == 0);
      hit_n  = mem_req && mem_slot;
      sel_n  = mem_sel; we_n = mem_we; addr_n = mem_addr; wd_n = mem_wdata;
   end

   always @(posedge clk) begin
      if (hit_n) begin
         acc_cnt++;
         if (we_n) begin
            case (sel_n)
               2'b01: ds_m[addr_n] = wd_n;
               2'b10: cml_m[addr_n] = wd_n;
               2'b11: cmh_m[addr_n] = wd_n;
               default: ;
            endcase
         end else begin
            case (sel_n)
               2'b01: mem_rdata <= ds_m[addr_n];
               2'b10: mem_rdata <= cml_m[addr_n];
               2'b11: mem_rdata <= cmh_m[addr_n];
               default: mem_rdata <= 8'hEE;
            endcase
         end
         hit_n = 0;
      end
   end

   // scoreboard
   logic [7:0] exp_q [$];
   string      tag_q [$];
   bit         oe_prev = 0;

   always @(negedge clk) begin
      if (bus_rdata_oe && !oe_prev) begin
         if (exp_q.size() == 0) chk("unexpected read data R10", 32'(bus_rdata), 32'hFFFF);
         else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, 32'(bus_rdata), 32'(e));
         end
      end
      oe_prev = bus_rdata_oe;
   end

   // bus driver
   task automatic bus_start(bit rd, logic [5:0] a, logic [7:0] wd, logic [7:0] e, string t);
      @(negedge clk);
      if (rd) begin exp_q.push_back(e); tag_q.push_back(t); end
      bus_rd = rd; bus_addr = a; bus_wdata = wd;
      bus_cs_n = 1'b0; bus_ds = 1'b1;
   endtask

   task automatic bus_wait_ack();
      while (bus_ack_n) @(negedge clk);
      if (!bus_rd) chk("oe low on write R10", 32'(bus_rdata_oe), 0);
   endtask

   task automatic bus_end();
      @(negedge clk);
      bus_ds = 1'b0; bus_cs_n = 1'b1;
      while (!bus_ack_n) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic access(bit rd, logic [5:0] a, logic [7:0] wd, logic [7:0] e, string t);
      bus_start(rd, a, wd, e, t);
      bus_wait_ack();
      bus_end();
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      int c0;
      for (int i = 0; i < 256; i++) begin
         ds_m[i] = 8'(i * 7 + 1); cml_m[i] = 8'h00; cmh_m[i] = 8'h00;
      end
      ds_m[73] = 8'h3C;
      ds_m[39] = 8'hC3;
      cmh_m[36] = 8'h5A;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 ack_n in reset", 32'(bus_ack_n), 1);
      chk("R1 oe in reset", 32'(bus_rdata_oe), 0);
      chk("R1 mem_req in reset", 32'(mem_req), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 msg_all after reset", 32'(ctl_msg_all), 0);
      access(1, 6'h00, 8'h00, 8'h00, "R1 control reads zero");

      // R2 / R3 control register
      c0 = acc_cnt;
      access(0, 6'h1F, 8'hFF, 8'h00, "");
      chk("R3 msg_all set", 32'(ctl_msg_all), 1);
      access(1, 6'h0A, 8'h00, 8'hDF, "R2 control readback, bit5 zero");
      chk("R2 no memory access", 32'(acc_cnt - c0), 0);

      // R4 connection-low, stream 3
      access(0, 6'h00, 8'h13, 8'h00, "");
      chk("R3 msg_all cleared", 32'(ctl_msg_all), 0);
      c0 = acc_cnt;
      access(0, 6'h25, 8'hA5, 8'h00, "");
      chk("R4 cml write lands", 32'(cml_m[101]), 32'hA5);
      chk("R6 one access cml write", 32'(acc_cnt - c0), 1);
      access(1, 6'h25, 8'h00, 8'hA5, "R4 cml readback");

      // R7 connection-high masking, stream 6 channel 31
      access(0, 6'h00, 8'h1E, 8'h00, "");
      access(0, 6'h3F, 8'hFF, 8'h00, "");
      chk("R4 cmh write lands", 32'(cmh_m[223]), 32'hFF);
      access(1, 6'h3F, 8'h00, 8'h07, "R7 cmh upper bits zero");

      // data store read and ignored write, stream 2 channel 9
      access(0, 6'h00, 8'h0A, 8'h00, "");
      access(1, 6'h29, 8'h00, 8'h3C, "R7 data store read");
      c0 = acc_cnt;
      access(0, 6'h29, 8'h55, 8'h00, "");
      chk("R8 ds write no access", 32'(acc_cnt - c0), 0);
      chk("R8 ds write ignored", 32'(ds_m[73]), 32'h3C);
      access(1, 6'h29, 8'h00, 8'h3C, "R8 ds unchanged via port");

      // reserved memory field
      access(0, 6'h00, 8'h02, 8'h00, "");
      c0 = acc_cnt;
      access(1, 6'h21, 8'h00, 8'h00, "R8 reserved read zero");
      access(0, 6'h21, 8'h99, 8'h00, "");
      chk("R8 reserved no access", 32'(acc_cnt - c0), 0);

      // R5 split mode, memory field says connection-high, stream 1
      access(0, 6'h00, 8'h99, 8'h00, "");
      access(0, 6'h24, 8'h77, 8'h00, "");
      chk("R5 split write to cml", 32'(cml_m[36]), 32'h77);
      chk("R5 split cmh untouched", 32'(cmh_m[36]), 32'h5A);
      access(1, 6'h27, 8'h00, 8'hC3, "R5 split read from ds");

      // R6 blocked slots
      access(0, 6'h00, 8'h10, 8'h00, "");
      slot_block = 1;
      c0 = acc_cnt;
      bus_start(0, 6'h22, 8'h6B, 8'h00, "");
      repeat (30) @(negedge clk);
      chk("R6 req held while blocked", 32'(mem_req), 1);
      chk("R6 no ack while blocked", 32'(bus_ack_n), 1);
      chk("R6 no access while blocked", 32'(acc_cnt - c0), 0);
      slot_block = 0;
      bus_wait_ack();
      bus_end();
      chk("R6 single access after unblock", 32'(acc_cnt - c0), 1);
      chk("R6 data after unblock", 32'(cml_m[2]), 32'h6B);

      // R9 ack held while strobe held; no second access
      c0 = acc_cnt;
      bus_start(1, 6'h22, 8'h00, 8'h6B, "R9 held read data");
      bus_wait_ack();
      repeat (10) @(negedge clk);
      chk("R9 ack held", 32'(bus_ack_n), 0);
      chk("R9 no second access", 32'(acc_cnt - c0), 1);
      bus_ds = 1'b0;
      repeat (5) @(negedge clk);
      chk("R9 ack released on ds low", 32'(bus_ack_n), 1);
      chk("R10 oe released", 32'(bus_rdata_oe), 0);
      bus_cs_n = 1'b1;
      repeat (3) @(negedge clk);

      chk("scoreboard drained", 32'(exp_q.size()), 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule